// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block sits beside a real-time clock counter chain and provides two independent alarms. The counters present the current time as BCD bytes (seconds, minutes, hours, date, month, day of week) together with a one-cycle advance strobe. The strobe is raised in the cycle in which the new time values are already on the inputs. Compares happen only on that strobe, so an alarm fires when the clock steps into a matching time and not on every clock.

The first alarm has six fields. The second alarm has three: minutes, hours, and one byte shared between day of week and date. The second alarm is only ever evaluated on a minute boundary. In every alarm byte, bit 7 is a per-field match enable and the lower bits hold the BCD value. A fired alarm sets a sticky flag. Each flag can drive an active-low interrupt line through its own interrupt enable. Flags are cleared by writing zero to them, or by reading the status byte when the auto-clear option is on.

A simple parallel register port gives access to all state. Read data is a combinational function of the address.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset every register and both flags are zero, every address reads 0x00, and `irq_n` is high for as long as reset is held and afterwards.
- R2: Register map. Addresses 0 to 5 hold the first alarm's seconds, minutes, hours, date, month and day-of-week bytes. Addresses 6 to 8 hold the second alarm's minutes, hours and day/date bytes. Address 9 is control: bit0 turns the first alarm on, bit1 turns the second alarm on, bit2 is the first interrupt enable, bit3 is the second interrupt enable, bit4 is auto-clear, and bits 7:5 read 0. Address 10 is status: bit0 is the first flag and bit1 is the second flag. Any other address reads 0x00 and ignores writes.
- R3: On a strobe cycle with the first alarm on, its flag sets at the following clock edge when every enabled field's bits 6:0 equal bits 6:0 of the matching time byte.
- R4: The first alarm never fires if none of its six bit-7 enables is set.
- R5: The second alarm is evaluated only on strobe cycles where the seconds input is 0x00. Its enabled minutes, hours and day/date fields must all match.
- R6: In the second alarm's day/date byte, bit 6 selects the target: 1 compares bits 5:0 with day of week, 0 compares them with date. For example, 0xC1 matches Monday (day 1).
- R7: With the second alarm on and all three of its enables clear, it fires on every strobe whose seconds input is 0x00.
- R8: Flags never set in a cycle without the strobe, whatever the time inputs show.
- R9: A write to status clears each flag whose written bit is 0. Written 1s leave the flags unchanged.
- R10: With auto-clear set, a read strobe at address 10 clears both flags. A flag set by the strobe in that same cycle stays set. Without auto-clear, reads do not change the flags.
- R11: `irq_n` is low exactly when some flag is set together with its interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-advance strobe |
| t_sec | input | DATA_W | Current seconds, BCD |
| t_min | input | DATA_W | Current minutes, BCD |
| t_hour | input | DATA_W | Current hours (24 h), BCD |
| t_date | input | DATA_W | Current date, BCD |
| t_month | input | DATA_W | Current month, BCD |
| t_dow | input | DATA_W | Current day of week |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on status only) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench aims at the masking corners. If a first alarm with no fields enabled were treated as "all match", it would fire on every second. A fully masked second alarm that ignored the seconds gate would fire sixty times a minute instead of once. The day/date selector is driven with a date and a day of week that disagree, so a swapped selector matches the wrong one. The bench also hits a status read in the same cycle as a new match: a design that lets the clear win loses that alarm. It also writes ones to status, which a wrong design treats as a set or as a clear.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   localparam int A1_NF      = 6;
   localparam int A2_NF      = 3;
   localparam int EN_BIT     = 7;
   localparam int DD_SEL_BIT = 6;
   localparam int CMP_W      = 7;
   localparam int DD_W       = 6;

   localparam int AD_A1_BASE = 0;
   localparam int AD_A2_BASE = 6;
   localparam int AD_CTRL    = 9;
   localparam int AD_STAT    = 10;

   typedef struct packed {
      logic auto_clr;
      logic a2_ie;
      logic a1_ie;
      logic a2_on;
      logic a1_on;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [1:0]                      flags,
   output logic [A1_NF-1:0][DATA_W-1:0]    a1_q,
   output logic [A2_NF-1:0][DATA_W-1:0]    a2_q,
   output ctrl_t                           ctrl_q,
   output logic [DATA_W-1:0]               rdata
);

   localparam logic [ADDR_W-1:0] CTRL_AD = ADDR_W'(AD_CTRL);
   localparam logic [ADDR_W-1:0] STAT_AD = ADDR_W'(AD_STAT);

   generate
      for (genvar i = 0; i < A1_NF; i++) begin : g_a1
         localparam logic [ADDR_W-1:0] MY_AD = ADDR_W'(AD_A1_BASE + i);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= '0;
            else if (wr_en && addr == MY_AD) q <= wdata;
         end
         assign a1_q[i] = q;
      end
      for (genvar k = 0; k < A2_NF; k++) begin : g_a2
         localparam logic [ADDR_W-1:0] MY_AD = ADDR_W'(AD_A2_BASE + k);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= '0;
            else if (wr_en && addr == MY_AD) q <= wdata;
         end
         assign a2_q[k] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ctrl_q <= '0;
      else if (wr_en && addr == CTRL_AD) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < A1_NF; i++)
         if (addr == ADDR_W'(AD_A1_BASE + i)) rdata = a1_q[i];
      for (int k = 0; k < A2_NF; k++)
         if (addr == ADDR_W'(AD_A2_BASE + k)) rdata = a2_q[k];
      if (addr == CTRL_AD) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      if (addr == STAT_AD) rdata = {{(DATA_W-2){1'b0}}, flags};
   end

endmodule

// File: rtl/alarm1_match.sv
module alarm1_match
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                          tick,
   input  logic                          enable,
   input  logic [A1_NF-1:0][DATA_W-1:0]  alm,
   input  logic [A1_NF-1:0][DATA_W-1:0]  now,
   output logic                          hit
);

   logic [A1_NF-1:0] fen;
   logic [A1_NF-1:0] fok;

   generate
      for (genvar i = 0; i < A1_NF; i++) begin : g_field
         assign fen[i] = alm[i][EN_BIT];
         assign fok[i] = !fen[i] || (alm[i][CMP_W-1:0] == now[i][CMP_W-1:0]);
      end
   endgenerate

   // a fully masked first alarm is inert rather than always-true
   assign hit = tick && enable && (|fen) && (&fok);

endmodule

// File: rtl/alarm2_match.sv
module alarm2_match
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                          tick,
   input  logic                          enable,
   input  logic [A2_NF-1:0][DATA_W-1:0]  alm,
   input  logic [DATA_W-1:0]             sec,
   input  logic [DATA_W-1:0]             minute,
   input  logic [DATA_W-1:0]             hour,
   input  logic [DATA_W-1:0]             date,
   input  logic [DATA_W-1:0]             dow,
   output logic                          hit
);

   logic [DATA_W-1:0] dd_target;
   logic              ok_min, ok_hr, ok_dd, on_minute;

   assign dd_target = alm[2][DD_SEL_BIT] ? dow : date;

   assign ok_min = !alm[0][EN_BIT] || (alm[0][CMP_W-1:0] == minute[CMP_W-1:0]);
   assign ok_hr  = !alm[1][EN_BIT] || (alm[1][CMP_W-1:0] == hour[CMP_W-1:0]);
   assign ok_dd  = !alm[2][EN_BIT] || (alm[2][DD_W-1:0]  == dd_target[DD_W-1:0]);

   assign on_minute = (sec == '0);

   assign hit = tick && enable && on_minute && ok_min && ok_hr && ok_dd;

endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
   parameter int IRQ_REG = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] set,
   input  logic       wr_clr,
   input  logic [1:0] wmask,
   input  logic       rd_clr,
   input  logic [1:0] ie,
   output logic [1:0] flags,
   output logic       irq_n
);

   logic [1:0] clr;
   logic [1:0] f_n;

   always_comb begin
      clr = (wr_clr ? ~wmask : 2'b00) | (rd_clr ? 2'b11 : 2'b00);
      f_n = (flags & ~clr) | set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= f_n;
   end

   generate
      if (IRQ_REG == 0) begin : g_irq_comb
         assign irq_n = ~|(flags & ie);
      end else begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= ~|(f_n & ie);
         end
         assign irq_n = irq_q;
      end
   endgenerate

endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4,
   parameter int IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] t_sec,
   input  logic [DATA_W-1:0] t_min,
   input  logic [DATA_W-1:0] t_hour,
   input  logic [DATA_W-1:0] t_date,
   input  logic [DATA_W-1:0] t_month,
   input  logic [DATA_W-1:0] t_dow,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_n
);

   localparam logic [ADDR_W-1:0] STAT_AD = ADDR_W'(AD_STAT);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be at least 8");
      end
      if ((1 << ADDR_W) <= AD_STAT) begin : g_bad_addr_w
         $error("ADDR_W too small for the register map");
      end
      if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
         $error("IRQ_REG must be 0 or 1");
      end
   endgenerate

   logic [A1_NF-1:0][DATA_W-1:0] a1_q;
   logic [A2_NF-1:0][DATA_W-1:0] a2_q;
   logic [A1_NF-1:0][DATA_W-1:0] now;
   ctrl_t                        ctrl_q;
   logic [1:0]                   flags;
   logic                         a1_hit, a2_hit;
   logic                         st_wr, st_rd;

   assign now   = {t_dow, t_month, t_date, t_hour, t_min, t_sec};
   assign st_wr = reg_wr && (reg_addr == STAT_AD);
   assign st_rd = reg_rd && (reg_addr == STAT_AD) && ctrl_q.auto_clr;

   alarm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .flags  (flags),
      .a1_q   (a1_q),
      .a2_q   (a2_q),
      .ctrl_q (ctrl_q),
      .rdata  (reg_rdata)
   );

   alarm1_match #(.DATA_W(DATA_W)) u_m1 (
      .tick   (tick),
      .enable (ctrl_q.a1_on),
      .alm    (a1_q),
      .now    (now),
      .hit    (a1_hit)
   );

   alarm2_match #(.DATA_W(DATA_W)) u_m2 (
      .tick   (tick),
      .enable (ctrl_q.a2_on),
      .alm    (a2_q),
      .sec    (t_sec),
      .minute (t_min),
      .hour   (t_hour),
      .date   (t_date),
      .dow    (t_dow),
      .hit    (a2_hit)
   );

   alarm_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    ({a2_hit, a1_hit}),
      .wr_clr (st_wr),
      .wmask  (reg_wdata[1:0]),
      .rd_clr (st_rd),
      .ie     ({ctrl_q.a2_ie, ctrl_q.a1_ie}),
      .flags  (flags),
      .irq_n  (irq_n)
   );

endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int IRQ_REG = 0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tick,
   input logic [DATA_W-1:0]             t_sec,
   input logic [1:0]                    flags,
   input logic [A1_NF-1:0][DATA_W-1:0]  a1_q,
   input ctrl_t                         ctrl_q,
   input logic                          st_rd,
   input logic                          st_wr,
   input logic [DATA_W-1:0]             reg_wdata,
   input logic                          irq_n
);

   logic [A1_NF-1:0] fen;
   always_comb for (int i = 0; i < A1_NF; i++) fen[i] = a1_q[i][EN_BIT];

   always @(negedge clk)
      if (!rst_n) a_r1_irq_high_in_reset: assert (irq_n);

   a_r8_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~$past(flags)) != 2'b00) |-> $past(tick));

   a_r3_a1_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(ctrl_q.a1_on));

   a_r4_a1_needs_field: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(|fen));

   a_r5_a2_on_zero_sec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> ($past(t_sec) == '0));

   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_rd && !tick) |-> (flags == 2'b00));

   a_r9_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_wr && !tick && !st_rd) |-> (flags == ($past(flags) & $past(reg_wdata[1:0]))));

   generate
      if (IRQ_REG == 0) begin : g_irq_chk
         a_r11_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (flags == 2'b00) |-> irq_n);
      end
   endgenerate

endmodule

bind cal_alarm_unit alarm_unit_chk #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .t_sec     (t_sec),
   .flags     (flags),
   .a1_q      (a1_q),
   .ctrl_q    (ctrl_q),
   .st_rd     (st_rd),
   .st_wr     (st_wr),
   .reg_wdata (reg_wdata),
   .irq_n     (irq_n)
);

// File: tb/tb_cal_alarm_unit.sv
`timescale 1ns/1ps
module tb_cal_alarm_unit;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [7:0] t_sec, t_min, t_hour, t_date, t_month, t_dow;
   logic       reg_wr, reg_rd;
   logic [3:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       irq_n;

   always #10 clk = ~clk;

   cal_alarm_unit dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
      .t_date(t_date), .t_month(t_month), .t_dow(t_dow),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [5:0][7:0] m_a1;
   logic [2:0][7:0] m_a2;
   logic [4:0]      m_ctrl;
   logic [1:0]      m_f;

   function automatic logic [7:0] bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [5:0][7:0] mk_time(int s, int m, int h, int d, int mo, int w);
      return {bcd(w), bcd(mo), bcd(d), bcd(h), bcd(m), bcd(s)};
   endfunction

   function automatic logic exp_a1(logic [5:0][7:0] a, logic [5:0][7:0] t, logic on);
      logic any;
      logic ok;
      any = 1'b0;
      ok  = 1'b1;
      for (int i = 0; i < 6; i++)
         if (a[i][7]) begin
            any = 1'b1;
            if (a[i][6:0] != t[i][6:0]) ok = 1'b0;
         end
      return on && any && ok;
   endfunction

   function automatic logic exp_a2(logic [2:0][7:0] a, logic [5:0][7:0] t, logic on);
      logic [7:0] tgt;
      logic ok;
      tgt = a[2][6] ? t[5] : t[3];
      ok  = (t[0] == 8'h00);
      if (a[0][7] && a[0][6:0] != t[1][6:0]) ok = 1'b0;
      if (a[1][7] && a[1][6:0] != t[2][6:0]) ok = 1'b0;
      if (a[2][7] && a[2][5:0] != tgt[5:0])  ok = 1'b0;
      return on && ok;
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_wr(int a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a < 6)        m_a1[a] = d;
      else if (a < 9)   m_a2[a-6] = d;
      else if (a == 9)  m_ctrl = d[4:0];
      else if (a == 10) m_f = m_f & d[1:0];
   endtask

   task automatic drive_time(logic [5:0][7:0] tv);
      t_sec = tv[0]; t_min = tv[1]; t_hour = tv[2];
      t_date = tv[3]; t_month = tv[4]; t_dow = tv[5];
   endtask

   task automatic do_tick(logic [5:0][7:0] tv, bit rd);
      logic [1:0] s;
      @(negedge clk);
      drive_time(tv);
      tick = 1'b1;
      if (rd) begin reg_rd = 1'b1; reg_addr = 4'd10; end
      @(negedge clk);
      tick = 1'b0; reg_rd = 1'b0;
      s = {exp_a2(m_a2, tv, m_ctrl[1]), exp_a1(m_a1, tv, m_ctrl[0])};
      if (rd && m_ctrl[4]) m_f = 2'b00;
      m_f = m_f | s;
   endtask

   task automatic do_rd();
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 4'd10;
      @(negedge clk);
      reg_rd = 1'b0;
      if (m_ctrl[4]) m_f = 2'b00;
   endtask

   task automatic check_state(string tag);
      reg_addr = 4'd10;
      #2;
      chk({tag, " flags"}, 32'(reg_rdata), {30'd0, m_f});
      chk({tag, " irq_n"}, 32'(irq_n), 32'(~|(m_f & m_ctrl[3:2])));
   endtask

   task automatic peek(int a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = 4'(a);
      #2;
      v = reg_rdata;
   endtask

   task automatic zero_all();
      for (int a = 0; a < 10; a++) do_wr(a, 8'h00);
      do_wr(10, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]      v;
      logic [5:0][7:0] tv;
      void'($urandom(32'h5EED_A1A2));
      rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_addr = '0; reg_wdata = '0;
      drive_time('0);
      m_a1 = '0; m_a2 = '0; m_ctrl = '0; m_f = '0;
      repeat (3) @(negedge clk);
      chk("R1 irq_n in reset", 32'(irq_n), 32'd1);
      rst_n = 1'b1;

      // R1: reset state on every address
      for (int a = 0; a < 16; a++) begin
         peek(a, v);
         chk($sformatf("R1 reset read addr %0d", a), 32'(v), 32'd0);
      end
      chk("R1 irq_n after reset", 32'(irq_n), 32'd1);

      // R2: register map readback
      for (int a = 0; a < 9; a++) begin
         logic [7:0] d;
         d = 8'($urandom);
         do_wr(a, d);
         peek(a, v);
         chk($sformatf("R2 readback addr %0d", a), 32'(v), 32'(d));
      end
      do_wr(9, 8'hE0);
      peek(9, v);
      chk("R2 ctrl upper bits", 32'(v), 32'h00);
      do_wr(11, 8'hAA);
      do_wr(15, 8'h55);
      peek(11, v);
      chk("R2 unmapped 11", 32'(v), 32'h00);
      peek(15, v);
      chk("R2 unmapped 15", 32'(v), 32'h00);
      zero_all();

      // R4: first alarm on, values equal but no field enabled
      do_wr(9, 8'h05);
      do_wr(1, 8'h30); do_wr(2, 8'h11);
      do_tick(mk_time(0, 30, 11, 1, 1, 1), 0);
      check_state("R4 no field enabled");

      // R3: minutes 30 and hours 11 enabled
      do_wr(1, 8'hB0); do_wr(2, 8'h91);
      do_tick(mk_time(5, 30, 11, 14, 6, 3), 0);
      check_state("R3 match 11:30");
      do_wr(10, 8'h00);
      do_tick(mk_time(0, 31, 11, 14, 6, 3), 0);
      check_state("R3 no match 11:31");

      // R8: matching time held without strobe
      @(negedge clk);
      drive_time(mk_time(7, 30, 11, 2, 2, 2));
      repeat (4) @(negedge clk);
      check_state("R8 no strobe");
      zero_all();

      // R5: second alarm minutes 15, seconds gate
      do_wr(9, 8'h0A);
      do_wr(6, 8'h95);
      do_tick(mk_time(7, 15, 9, 3, 4, 5), 0);
      check_state("R5 seconds not zero");
      do_tick(mk_time(0, 15, 9, 3, 4, 5), 0);
      check_state("R5 match at seconds 00");
      do_wr(10, 8'h00);

      // R6: day/date selector
      do_wr(6, 8'h00); do_wr(8, 8'hC1);
      do_tick(mk_time(0, 0, 20, 1, 1, 2), 0);
      check_state("R6 dow select, date 1 dow 2");
      do_tick(mk_time(0, 0, 20, 9, 1, 1), 0);
      check_state("R6 dow select, dow 1");
      do_wr(10, 8'h00);
      do_wr(8, 8'h81);
      do_tick(mk_time(0, 0, 20, 2, 1, 1), 0);
      check_state("R6 date select, date 2 dow 1");
      do_tick(mk_time(0, 0, 20, 1, 1, 4), 0);
      check_state("R6 date select, date 1");
      zero_all();

      // R7: second alarm fully masked
      do_wr(9, 8'h0A);
      do_tick(mk_time(0, 42, 10, 5, 5, 5), 0);
      check_state("R7 every minute at 00");
      do_wr(10, 8'h00);
      do_tick(mk_time(30, 42, 10, 5, 5, 5), 0);
      check_state("R7 silent at 30");

      // R9: status write semantics, both flags set
      do_wr(9, 8'h0F);
      do_wr(0, 8'h80);
      do_tick(mk_time(0, 1, 1, 1, 1, 1), 0);
      check_state("R9 both set");
      do_wr(10, 8'hFF);
      check_state("R9 write ones keeps");
      do_wr(10, 8'h01);
      check_state("R9 write 01 clears second only");
      do_wr(10, 8'h00);
      check_state("R9 write 00 clears");

      // R11: interrupt gating by enables
      do_tick(mk_time(0, 2, 1, 1, 1, 1), 0);
      check_state("R11 irq low");
      do_wr(9, 8'h03);
      check_state("R11 irq released by ie off");
      do_wr(9, 8'h07);
      check_state("R11 first ie only");
      zero_all();

      // R10: auto-clear on read, set wins
      do_wr(9, 8'h15);
      do_wr(0, 8'h85);
      do_tick(mk_time(5, 0, 0, 1, 1, 1), 0);
      check_state("R10 set before read");
      do_rd();
      check_state("R10 read clears");
      do_tick(mk_time(5, 9, 0, 1, 1, 1), 1);
      check_state("R10 set wins over read");
      do_wr(9, 8'h05);
      do_rd();
      check_state("R10 no clear without auto");
      zero_all();

      // random mix across R3, R5, R6, R10
      for (int it = 0; it < 250; it++) begin
         bit rd;
         tv = mk_time(($urandom % 4 == 0) ? 0 : $urandom % 60, $urandom % 60,
                      $urandom % 24, 1 + $urandom % 31, 1 + $urandom % 12, 1 + $urandom % 7);
         for (int i = 0; i < 6; i++) begin
            logic [7:0] fv;
            fv = ($urandom % 5 == 0) ? (tv[i] ^ 8'h01) : tv[i];
            do_wr(i, {1'($urandom % 2), fv[6:0]});
         end
         for (int k = 0; k < 2; k++) begin
            logic [7:0] fv;
            fv = ($urandom % 5 == 0) ? (tv[k+1] ^ 8'h01) : tv[k+1];
            do_wr(6 + k, {1'($urandom % 2), fv[6:0]});
         end
         begin
            logic       sel;
            logic [7:0] fv;
            sel = 1'($urandom % 2);
            fv  = sel ? tv[5] : tv[3];
            if ($urandom % 5 == 0) fv = fv ^ 8'h02;
            do_wr(8, {1'($urandom % 2), sel, fv[5:0]});
         end
         do_wr(9, 8'($urandom % 32));
         rd = ($urandom % 4 == 0);
         do_tick(tv, rd);
         check_state("R3 R5 R6 random tick");
         if ($urandom % 3 == 0) begin
            do_rd();
            check_state("R10 random read");
         end
         do_wr(10, 8'h00);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule